// File: doc/BRIEF.md
# Dual-Core Mailbox Array

This block sits between two processor cores and gives them a set of mailbox channels and a separate set of doorbell interrupt structures. Either core may use any channel. A channel is a hardware lock that one core at most holds at a time, paired with a 32-bit word that only the lock holder may change. A core takes a channel with a single read of that channel's acquire register. The returned bit says whether the lock was won, and a successful read also records the core as owner in that same access.

The doorbells are independent of the channels. A core writes a notify or an acknowledge register with one bit per target core, which raises a pending flag on that target. Each core masks its own flags per doorbell and clears them by writing ones. The usual message flow is: the sender locks a channel, writes the word and notifies; the receiver reads the word, releases the lock and acknowledges. When the sender owns the channel, the receiver's release is ignored, so in that flow the sender frees the channel itself.

Each core has its own access port: request, write enable, an 8-bit word address and 32-bit write data, with read data returned one cycle later. The address is split as {region[7:6], index[5:2], register[1:0]}. Region 0 holds the channels: register 0 is acquire (read), 1 is release (write) and 2 is the data word. Region 1 holds the doorbells: register 0 is notify (write), 1 is acknowledge (write), 2 is the accessing core's mask and 3 is the accessing core's pending flags. Region 2 is the lock status word. A read of any other location returns zero, and writes to other locations, including the acquire register, change nothing.

Top module: `xcore_mailbox`

## Requirements
- R1: After a synchronous reset every channel is free with owner 0 and data 0, all pending and mask bits are 0, both read-data outputs are 0 and all interrupt outputs are low.
- R2: A read of a free channel's acquire register returns 1 in bit 0, locks the channel and records the reader (0 or 1) as owner. A read of a locked channel's acquire register returns 0 and changes nothing, including when the reader already owns it.
- R3: When both cores read the acquire register of the same free channel in one cycle, core 0 receives 1 and owns the channel, and core 1 receives 0. Acquires of two different free channels in one cycle both succeed.
- R4: A release write from the owner of a locked channel frees it. A release write from the other core, or to a free channel, leaves lock and owner unchanged. An acquire by the other core in the same cycle as a release still sees the channel locked.
- R5: A data write stores the 32-bit word only when the channel is locked by the writing core. Otherwise it is ignored. Either core may read the data word at any time.
- R6: The status word has channel k's lock flag in bit 2k and its owner in bit 2k+1 (1 means core 1).
- R7: A notify write sets the notify pending flag (bit 0) of every target core whose bit is set in write-data bits [1:0] (bit 0 targets core 0, bit 1 targets core 1). An acknowledge write sets the acknowledge pending flag (bit 1) of those targets in the same way. Writes from both cores are combined by OR.
- R8: The mask register holds two enable bits per core per doorbell (bit 0 enables notify, bit 1 enables acknowledge). A core's interrupt output for a doorbell is high exactly when some pending flag of that core and doorbell has its enable bit set.
- R9: Writing the pending register clears the accessing core's flags wherever the write-data bit is 1. A set and a clear of the same flag in one cycle leaves it set.
- R10: Read data appears at the clock edge that ends the read access and holds until the next read by the same core. Reads of write-only or unmapped locations return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| c0Req | input | 1 | Core 0 access request |
| c0Wr | input | 1 | Core 0 write enable (0 means read) |
| c0Addr | input | 8 | Core 0 word address |
| c0WData | input | 32 | Core 0 write data |
| c0RData | output | 32 | Core 0 read data, registered |
| c0Irq | output | NUM_IRQ | Core 0 interrupt per doorbell |
| c1Req | input | 1 | Core 1 access request |
| c1Wr | input | 1 | Core 1 write enable (0 means read) |
| c1Addr | input | 8 | Core 1 word address |
| c1WData | input | 32 | Core 1 write data |
| c1RData | output | 32 | Core 1 read data, registered |
| c1Irq | output | NUM_IRQ | Core 1 interrupt per doorbell |

## Verification
Every result is due one clock edge after its access. Read data, including the acquire outcome, is registered at the edge that ends the access. Lock, owner, data, mask and pending updates take effect at that same edge, so a status or data read issued in the next cycle already shows them. Interrupt outputs follow the pending and mask registers with no further delay. The bench steps a behavioural model at each rising edge from the same inputs, then compares both read-data ports and both interrupt vectors at the falling edge, after the design's registers have settled.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_DATA_W = 32;
  localparam int MB_ADDR_W = 8;
  localparam int MB_IDX_W  = 4;

  typedef enum logic [2:0] {
    RD_NONE, RD_ZERO, RD_ACQ, RD_DATA, RD_MASK, RD_PEND, RD_STAT
  } rdKind_e;

  // One core's decoded, already ownership-checked access for this cycle
  typedef struct packed {
    logic                 acqGrant;
    logic                 relDo;
    logic                 dataWr;
    logic [1:0]           ntfSet;
    logic [1:0]           ackSet;
    logic                 maskWr;
    logic                 pendClr;
    logic [MB_IDX_W-1:0]  idx;
    logic [MB_DATA_W-1:0] wdata;
    rdKind_e              rdKind;
  } coreStrb_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_IRQ = 16
) (
  input  logic [1:0]                busReq,
  input  logic [1:0]                busWr,
  input  logic [1:0][MB_ADDR_W-1:0] busAddr,
  input  logic [1:0][MB_DATA_W-1:0] busWData,
  input  logic [NUM_CH-1:0]         lockV,
  input  logic [NUM_CH-1:0]         ownerV,
  output coreStrb_t [1:0]           strb
);
  localparam logic [MB_IDX_W:0] CH_LIM  = (MB_IDX_W+1)'(NUM_CH);
  localparam logic [MB_IDX_W:0] IRQ_LIM = (MB_IDX_W+1)'(NUM_IRQ);

  logic [1:0] chHit, irqHit, stHit, rdOp, wrOp, ownHit;
  logic [1:0][MB_IDX_W-1:0] idxV;
  logic [1:0][1:0] regV;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      idxV[c]   = busAddr[c][2 +: MB_IDX_W];
      regV[c]   = busAddr[c][1:0];
      rdOp[c]   = busReq[c] && !busWr[c];
      wrOp[c]   = busReq[c] && busWr[c];
      chHit[c]  = (busAddr[c][MB_ADDR_W-1 -: 2] == 2'd0) && ({1'b0, idxV[c]} < CH_LIM);
      irqHit[c] = (busAddr[c][MB_ADDR_W-1 -: 2] == 2'd1) && ({1'b0, idxV[c]} < IRQ_LIM);
      stHit[c]  = (busAddr[c][MB_ADDR_W-1 -: 2] == 2'd2);
      ownHit[c] = lockV[idxV[c]] && (ownerV[idxV[c]] == (c != 0));

      strb[c]          = '0;
      strb[c].idx      = idxV[c];
      strb[c].wdata    = busWData[c];
      strb[c].acqGrant = rdOp[c] && chHit[c] && regV[c] == 2'd0 && !lockV[idxV[c]];
      strb[c].relDo    = wrOp[c] && chHit[c] && regV[c] == 2'd1 && ownHit[c];
      strb[c].dataWr   = wrOp[c] && chHit[c] && regV[c] == 2'd2 && ownHit[c];
      strb[c].ntfSet   = (wrOp[c] && irqHit[c] && regV[c] == 2'd0) ? busWData[c][1:0] : 2'b00;
      strb[c].ackSet   = (wrOp[c] && irqHit[c] && regV[c] == 2'd1) ? busWData[c][1:0] : 2'b00;
      strb[c].maskWr   = wrOp[c] && irqHit[c] && regV[c] == 2'd2;
      strb[c].pendClr  = wrOp[c] && irqHit[c] && regV[c] == 2'd3;

      if (!rdOp[c])                           strb[c].rdKind = RD_NONE;
      else if (chHit[c] && regV[c] == 2'd0)   strb[c].rdKind = RD_ACQ;
      else if (chHit[c] && regV[c] == 2'd2)   strb[c].rdKind = RD_DATA;
      else if (irqHit[c] && regV[c] == 2'd2)  strb[c].rdKind = RD_MASK;
      else if (irqHit[c] && regV[c] == 2'd3)  strb[c].rdKind = RD_PEND;
      else if (stHit[c])                      strb[c].rdKind = RD_STAT;
      else                                    strb[c].rdKind = RD_ZERO;
    end
    // Fixed priority: core 0 wins a same-cycle race for one channel
    if (strb[0].acqGrant && strb[0].idx == strb[1].idx)
      strb[1].acqGrant = 1'b0;
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_IRQ = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  coreStrb_t [1:0]           strb,
  output logic [NUM_CH-1:0]         lockV,
  output logic [NUM_CH-1:0]         ownerV,
  output logic [1:0][MB_DATA_W-1:0] rdData,
  output logic [1:0][NUM_IRQ-1:0]   irqOut
);
  logic [MB_DATA_W-1:0] dataMem [NUM_CH];
  logic [1:0][NUM_IRQ-1:0][1:0] pend, mask, pendNext;
  logic [MB_DATA_W-1:0] statWord;
  logic [1:0][MB_DATA_W-1:0] rdVal;

  always_comb begin
    statWord = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      statWord[2*k]   = lockV[k];
      statWord[2*k+1] = ownerV[k];
    end
  end

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      for (int j = 0; j < NUM_IRQ; j++) begin
        logic [1:0] setB, clrB;
        setB = 2'b00;
        for (int s = 0; s < 2; s++) begin
          if (strb[s].idx == MB_IDX_W'(j)) begin
            setB[0] = setB[0] | strb[s].ntfSet[t];
            setB[1] = setB[1] | strb[s].ackSet[t];
          end
        end
        clrB = (strb[t].pendClr && strb[t].idx == MB_IDX_W'(j)) ? strb[t].wdata[1:0] : 2'b00;
        pendNext[t][j] = (pend[t][j] & ~clrB) | setB;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      rdVal[c] = '0;
      case (strb[c].rdKind)
        RD_ACQ:  rdVal[c][0]   = strb[c].acqGrant;
        RD_DATA: rdVal[c]      = dataMem[strb[c].idx];
        RD_MASK: rdVal[c][1:0] = mask[c][strb[c].idx];
        RD_PEND: rdVal[c][1:0] = pend[c][strb[c].idx];
        RD_STAT: rdVal[c]      = statWord;
        default: rdVal[c]      = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lockV  <= '0;
      ownerV <= '0;
      pend   <= '0;
      mask   <= '0;
      rdData <= '0;
      for (int k = 0; k < NUM_CH; k++) dataMem[k] <= '0;
    end else begin
      pend <= pendNext;
      for (int c = 0; c < 2; c++) begin
        if (strb[c].acqGrant) begin
          lockV[strb[c].idx]  <= 1'b1;
          ownerV[strb[c].idx] <= (c != 0);
        end
        if (strb[c].relDo)  lockV[strb[c].idx]   <= 1'b0;
        if (strb[c].dataWr) dataMem[strb[c].idx] <= strb[c].wdata;
        if (strb[c].maskWr) mask[c][strb[c].idx] <= strb[c].wdata[1:0];
        if (strb[c].rdKind != RD_NONE) rdData[c] <= rdVal[c];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++)
      for (int j = 0; j < NUM_IRQ; j++)
        irqOut[c][j] = |(pend[c][j] & mask[c][j]);
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chChk
    // R2
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(lockV[k]) |-> $past((strb[0].acqGrant && strb[0].idx == MB_IDX_W'(k)) ||
                                (strb[1].acqGrant && strb[1].idx == MB_IDX_W'(k))));
    // R4
    owner_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (lockV[k] && $past(lockV[k])) |-> $stable(ownerV[k]));
    // R5
    data_guard_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(dataMem[k]) |-> $past(lockV[k]));
  end

  for (genvar c = 0; c < 2; c++) begin : g_coreChk
    for (genvar j = 0; j < NUM_IRQ; j++) begin : g_irqChk
      // R8
      irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        irqOut[c][j] |-> (|mask[c][j]));
      // R9
      pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pend[c][j][0]) |-> $past(strb[c].pendClr && strb[c].idx == MB_IDX_W'(j)));
    end
  end
endmodule

// File: rtl/xcore_mailbox.sv
module xcore_mailbox
  import mbox_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_IRQ = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 c0Req,
  input  logic                 c0Wr,
  input  logic [MB_ADDR_W-1:0] c0Addr,
  input  logic [MB_DATA_W-1:0] c0WData,
  output logic [MB_DATA_W-1:0] c0RData,
  output logic [NUM_IRQ-1:0]   c0Irq,
  input  logic                 c1Req,
  input  logic                 c1Wr,
  input  logic [MB_ADDR_W-1:0] c1Addr,
  input  logic [MB_DATA_W-1:0] c1WData,
  output logic [MB_DATA_W-1:0] c1RData,
  output logic [NUM_IRQ-1:0]   c1Irq
);
  coreStrb_t [1:0] strb;
  logic [NUM_CH-1:0] lockV, ownerV;
  logic [1:0][MB_DATA_W-1:0] rdData;
  logic [1:0][NUM_IRQ-1:0] irqOut;

  mbox_ctrl #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) i_ctrl (
    .busReq   ({c1Req, c0Req}),
    .busWr    ({c1Wr, c0Wr}),
    .busAddr  ({c1Addr, c0Addr}),
    .busWData ({c1WData, c0WData}),
    .lockV    (lockV),
    .ownerV   (ownerV),
    .strb     (strb)
  );

  mbox_datapath #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) i_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .lockV  (lockV),
    .ownerV (ownerV),
    .rdData (rdData),
    .irqOut (irqOut)
  );

  assign c0RData = rdData[0];
  assign c1RData = rdData[1];
  assign c0Irq   = irqOut[0];
  assign c1Irq   = irqOut[1];
endmodule

// File: tb/test_xcore_mailbox.sv
`timescale 1ns/100ps
module test_xcore_mailbox;
  localparam int NCH = 16;
  localparam int NIRQ = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  bit rq[2];
  bit wv[2];
  logic [7:0] ad[2];
  logic [31:0] wd[2];
  logic [31:0] c0RData, c1RData;
  logic [NIRQ-1:0] c0Irq, c1Irq;

  xcore_mailbox i_xcore_mailbox (
    .clk(clk), .rst(rst),
    .c0Req(rq[0]), .c0Wr(wv[0]), .c0Addr(ad[0]), .c0WData(wd[0]),
    .c0RData(c0RData), .c0Irq(c0Irq),
    .c1Req(rq[1]), .c1Wr(wv[1]), .c1Addr(ad[1]), .c1WData(wd[1]),
    .c1RData(c1RData), .c1Irq(c1Irq)
  );

  // behavioural reference state
  int mLock[NCH];
  int mOwn[NCH];
  logic [31:0] mData[NCH];
  bit mPend[2][NIRQ][2];
  bit mMask[2][NIRQ][2];
  logic [31:0] mR[2];
  bit started = 0;
  bit done = 0;
  int nCmp = 0;
  int nBad = 0;
  string curReq = "R1";

  always @(posedge clk) begin : refModel
    int rgn[2];
    int ix[2];
    int rg[2];
    bit gr[2];
    int nL[NCH];
    int nO[NCH];
    logic [31:0] nD[NCH];
    bit nP[2][NIRQ][2];
    bit nM[2][NIRQ][2];
    logic [31:0] v;
    started = 1;
    if (rst) begin
      for (int k = 0; k < NCH; k++) begin mLock[k] = 0; mOwn[k] = 0; mData[k] = 0; end
      for (int c = 0; c < 2; c++) begin
        mR[c] = 0;
        for (int j = 0; j < NIRQ; j++)
          for (int b = 0; b < 2; b++) begin mPend[c][j][b] = 0; mMask[c][j][b] = 0; end
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        rgn[c] = int'(ad[c]) / 64;
        ix[c]  = (int'(ad[c]) / 4) % 16;
        rg[c]  = int'(ad[c]) % 4;
      end
      for (int c = 0; c < 2; c++)
        gr[c] = rq[c] && !wv[c] && rgn[c] == 0 && rg[c] == 0 && mLock[ix[c]] == 0;
      if (gr[0] && gr[1] && ix[0] == ix[1]) gr[1] = 0;
      for (int c = 0; c < 2; c++) begin
        if (rq[c] && !wv[c]) begin
          v = 0;
          if (rgn[c] == 0 && rg[c] == 0) v[0] = gr[c];
          else if (rgn[c] == 0 && rg[c] == 2) v = mData[ix[c]];
          else if (rgn[c] == 1 && rg[c] == 2) begin v[0] = mMask[c][ix[c]][0]; v[1] = mMask[c][ix[c]][1]; end
          else if (rgn[c] == 1 && rg[c] == 3) begin v[0] = mPend[c][ix[c]][0]; v[1] = mPend[c][ix[c]][1]; end
          else if (rgn[c] == 2)
            for (int k = 0; k < NCH; k++) begin v[2*k] = (mLock[k] != 0); v[2*k+1] = (mOwn[k] != 0); end
          mR[c] = v;
        end
      end
      nL = mLock; nO = mOwn; nD = mData; nP = mPend; nM = mMask;
      for (int c = 0; c < 2; c++) begin
        if (gr[c]) begin nL[ix[c]] = 1; nO[ix[c]] = c; end
        if (rq[c] && wv[c] && rgn[c] == 0 && mLock[ix[c]] != 0 && mOwn[ix[c]] == c) begin
          if (rg[c] == 1) nL[ix[c]] = 0;
          if (rg[c] == 2) nD[ix[c]] = wd[c];
        end
        if (rq[c] && wv[c] && rgn[c] == 1 && rg[c] == 2) begin
          nM[c][ix[c]][0] = wd[c][0]; nM[c][ix[c]][1] = wd[c][1];
        end
        if (rq[c] && wv[c] && rgn[c] == 1 && rg[c] == 3)
          for (int b = 0; b < 2; b++) if (wd[c][b]) nP[c][ix[c]][b] = 0;
      end
      for (int s = 0; s < 2; s++)
        if (rq[s] && wv[s] && rgn[s] == 1 && rg[s] < 2)
          for (int t = 0; t < 2; t++) if (wd[s][t]) nP[t][ix[s]][rg[s]] = 1;
      mLock = nL; mOwn = nO; mData = nD; mPend = nP; mMask = nM;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      for (int c = 0; c < 2; c++) begin
        logic [31:0] act;
        logic [NIRQ-1:0] ai, ei;
        act = (c == 0) ? c0RData : c1RData;
        ai  = (c == 0) ? c0Irq : c1Irq;
        for (int j = 0; j < NIRQ; j++)
          ei[j] = (mPend[c][j][0] & mMask[c][j][0]) | (mPend[c][j][1] & mMask[c][j][1]);
        nCmp++;
        if (act !== mR[c]) begin
          nBad++;
          $display("FAIL %s core%0d rdata act=%h exp=%h t=%0t", curReq, c, act, mR[c], $time);
        end
        nCmp++;
        if (ai !== ei) begin
          nBad++;
          $display("FAIL %s core%0d irq act=%h exp=%h t=%0t", curReq, c, ai, ei, $time);
        end
      end
    end
  end

  function automatic logic [7:0] chA(int i, int r);
    return {2'b00, 4'(i), 2'(r)};
  endfunction
  function automatic logic [7:0] irA(int i, int r);
    return {2'b01, 4'(i), 2'(r)};
  endfunction
  localparam logic [7:0] ST_A = 8'h80;

  task automatic both(bit r0, bit w0, logic [7:0] a0, logic [31:0] d0,
                      bit r1, bit w1, logic [7:0] a1, logic [31:0] d1);
    @(posedge clk); #1;
    rq[0] = r0; wv[0] = w0; ad[0] = a0; wd[0] = d0;
    rq[1] = r1; wv[1] = w1; ad[1] = a1; wd[1] = d1;
  endtask
  task automatic k0(bit w, logic [7:0] a, logic [31:0] d);
    both(1, w, a, d, 0, 0, 8'h0, 32'h0);
  endtask
  task automatic k1(bit w, logic [7:0] a, logic [31:0] d);
    both(0, 0, 8'h0, 32'h0, 1, w, a, d);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) both(0, 0, 8'h0, 32'h0, 0, 0, 8'h0, 32'h0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin rq[c] = 0; wv[c] = 0; ad[c] = 0; wd[c] = 0; end
    curReq = "R1";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    k0(0, ST_A, 0); k1(0, irA(0, 3), 0); k0(0, chA(9, 2), 0); idle(2);

    curReq = "R2";
    k0(0, chA(3, 0), 0); k0(0, chA(3, 0), 0); k1(0, chA(3, 0), 0); idle(1);

    curReq = "R6";
    k1(0, ST_A, 0); k0(0, chA(6, 0), 0); k1(0, chA(12, 0), 0); k0(0, ST_A, 0); idle(1);

    curReq = "R5";
    k1(1, chA(3, 2), 32'h1111_2222); k1(0, chA(3, 2), 0);
    k0(1, chA(3, 2), 32'hA5C3_0F96); k1(0, chA(3, 2), 0); k0(0, chA(3, 2), 0); idle(1);

    curReq = "R4";
    k1(1, chA(3, 1), 0); k0(0, ST_A, 0); k1(1, chA(0, 1), 0); k0(0, ST_A, 0);
    both(1, 1, chA(3, 1), 0, 1, 0, chA(3, 0), 0);
    k1(0, ST_A, 0); k1(0, chA(3, 0), 0); k0(0, ST_A, 0); idle(1);

    curReq = "R5";
    k0(1, chA(3, 2), 32'h7777_7777); k0(0, chA(3, 2), 0);
    k1(1, chA(3, 2), 32'h0BAD_F00D); k0(0, chA(3, 2), 0); idle(1);

    curReq = "R3";
    both(1, 0, chA(5, 0), 0, 1, 0, chA(5, 0), 0);
    both(1, 0, chA(7, 0), 0, 1, 0, chA(8, 0), 0);
    k0(0, ST_A, 0); idle(1);

    curReq = "R7";
    k0(1, irA(2, 0), 32'h2); k1(0, irA(2, 3), 0); k0(0, irA(2, 3), 0);
    k1(1, irA(4, 1), 32'h3); k0(0, irA(4, 3), 0); k1(0, irA(4, 3), 0);
    both(1, 1, irA(9, 0), 32'h1, 1, 1, irA(9, 0), 32'h2); idle(1);

    curReq = "R8";
    k1(1, irA(2, 2), 32'h1); k1(0, irA(2, 2), 0); k1(1, irA(2, 2), 32'h2);
    k1(1, irA(2, 2), 32'h3); k0(1, irA(4, 2), 32'h2); k0(1, irA(9, 2), 32'h1); idle(2);

    curReq = "R9";
    k1(1, irA(2, 3), 32'h1); k1(0, irA(2, 3), 0);
    k0(1, irA(4, 3), 32'h2); k0(0, irA(4, 3), 0);
    k1(1, irA(6, 2), 32'h3); k1(1, irA(6, 0), 32'h2);
    both(1, 1, irA(6, 0), 32'h2, 1, 1, irA(6, 3), 32'h1);
    k1(0, irA(6, 3), 0); k1(1, irA(6, 3), 32'h3); idle(2);

    curReq = "R10";
    k0(0, chA(5, 2), 0); idle(3); k0(1, chA(5, 2), 32'h1234_5678); idle(2);
    k0(0, chA(5, 1), 0); k1(0, irA(1, 0), 0); k0(0, 8'hC4, 0); k1(1, 8'hC0, 32'hFFFF_FFFF); idle(2);

    curReq = "R2 mixed traffic";
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a0, a1;
      a0 = {2'($urandom % 3), 2'b00, 2'($urandom), 2'($urandom)};
      a1 = {2'($urandom % 3), 2'b00, 2'($urandom), 2'($urandom)};
      both(1'($urandom), 1'($urandom), a0, $urandom, 1'($urandom), 1'($urandom), a1, $urandom);
    end
    idle(3);

    done = 1;
    summary();
    $finish;
  end
endmodule